// File: doc/BRIEF.md
# Floating-Point Status Flag Unit

This block keeps the seven status flags that sit beside a single-precision floating-point datapath and refreshes them once per clock from what that datapath just produced. Each cycle the block receives an operation-class code, the 32-bit value written to the destination, and the underflow and overflow indications from the arithmetic units. It also receives a boolean condition result for test operations. From these inputs it updates the zero and negative flags for integers and for floats, the test flag, and two sticky exception flags.

Two side channels run next to the operation path. A masked direct write loads any subset of the seven flags in one cycle, for flag-set and context-restore sequences. A copy strobe exports the flags as they stood before the clock edge and clears both sticky exception flags at that edge. When the float flags are formed, negative zero and denormal values count as positive zero. The arithmetic and the condition evaluation stay outside the block.

Top module: `fpflag_unit`

## Requirements
- R1: A synchronous active-low reset clears all seven flags to 0 at the next rising clock edge.
- R2: The flag register layout is bit 6 test, bit 5 integer zero, bit 4 integer negative, bit 3 float zero, bit 2 float negative, bit 1 sticky underflow, bit 0 sticky overflow. Move-class codes 1, 2 and 3 set bit 5 when all 32 value bits are zero and set bit 4 from value bit 31.
- R3: Move-class codes and codes 4 (absolute), 5 (negate), 6 (compare), 7 (maximum) and 8 (minimum) update bits 3 and 2 from the value. Bit 3 is set when the exponent field (bits 30:23) is all zero. Bit 2 is set when bit 31 is 1 and the exponent is nonzero. Negative zero and denormals of either sign therefore give zero=1, negative=0.
- R4: Codes 4 to 8 leave bits 5 and 4 unchanged.
- R5: Codes 9 to 14 (multiply, add, subtract, multiply-accumulate, reciprocal estimate, inverse square-root estimate) set bit 1 when the underflow input is 1 and set bit 0 when the overflow input is 1. Once set, these bits stay set until cleared by a copy or a direct write.
- R6: The underflow and overflow inputs have no effect under any code outside 9 to 14.
- R7: Code 15 (test) loads bit 6 from the condition input. No other code changes bit 6.
- R8: When the direct write enable is 1, every flag whose mask bit is 1 takes the matching data bit at the edge. This write overrides any update from the operation or the copy in the same cycle.
- R9: While the copy strobe is 1, the copy output equals the flag register before the edge, and bits 1 and 0 clear at that edge while bits 6 to 2 are untouched. While the strobe is 0, the copy output is zero.
- R10: An under/overflow event from codes 9 to 14 in the same cycle as a copy leaves its sticky bit set.
- R11: Code 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation-class code for this cycle |
| value_i | input | 32 | Value written to the destination, or the result of a compare, maximum or minimum |
| uf_i | input | 1 | Underflow reported by the arithmetic unit |
| of_i | input | 1 | Overflow reported by the arithmetic unit |
| cond_i | input | 1 | Result of the tested condition, 1 = true |
| wr_en_i | input | 1 | Direct flag write enable |
| wr_mask_i | input | 7 | Per-flag write mask |
| wr_data_i | input | 7 | Per-flag write data |
| copy_i | input | 1 | Copy-out strobe; clears the sticky flags |
| flags_o | output | 7 | Current flag register |
| copy_o | output | 7 | Flags before the edge while copy_i is 1, else zero |

## Verification
Two things can act on a sticky exception flag in the same cycle: an arithmetic event and a clearing copy, or an arithmetic event and a masked direct write. The bench gives each collision its own vector. In one, a subtract reports overflow in the cycle a copy is strobed; the bench checks that the copy output shows the older flags and that the overflow bit is still set afterwards. In the other, a reciprocal estimate reports both conditions while a direct write of zeros targets bits 1 and 0; the bench checks that both bits read zero. A move combined with a masked write of the integer-zero flag checks the same precedence on a non-sticky bit.

// File: rtl/fpflag_pkg.sv
// Package: shared widths, flag bit positions and operation codes of the
// floating-point status flag unit. Assumes IEEE single-precision layout.
package fpflag_pkg;

    localparam int FLAG_W = 7;
    localparam int OP_W   = 4;

    // Flag positions: neighbours decode these bits, so they are fixed.
    localparam int B_TEST = 6;
    localparam int B_IZ   = 5;
    localparam int B_IN   = 4;
    localparam int B_FZ   = 3;
    localparam int B_FN   = 2;
    localparam int B_UF   = 1;
    localparam int B_OF   = 0;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'd0,
        OP_MOVA  = 4'd1,
        OP_MOVB  = 4'd2,
        OP_MOVC  = 4'd3,
        OP_ABS   = 4'd4,
        OP_NEG   = 4'd5,
        OP_CMP   = 4'd6,
        OP_MAX   = 4'd7,
        OP_MIN   = 4'd8,
        OP_MUL   = 4'd9,
        OP_ADD   = 4'd10,
        OP_SUB   = 4'd11,
        OP_MAC   = 4'd12,
        OP_RCP   = 4'd13,
        OP_RSQ   = 4'd14,
        OP_TEST  = 4'd15
    } op_e;

    // Which flag groups one operation class refreshes.
    typedef struct packed {
        logic upd_int;
        logic upd_fp;
        logic upd_test;
        logic arith;
    } upd_t;

endpackage

// File: rtl/fpflag_classify.sv
// Module: fpflag_classify
// Forms the integer and float zero/negative indications of one value.
// Assumes a sign bit on top, then EXP_W exponent bits, then the mantissa.
// A zero exponent (true zero, negative zero, denormal) reads as positive zero.
module fpflag_classify #(
    parameter int DATA_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic [DATA_W-1:0] value_i,
    output logic              int_zero_o,
    output logic              int_neg_o,
    output logic              fp_zero_o,
    output logic              fp_neg_o
);
    localparam int SIGN_B = DATA_W - 1;
    localparam int EXP_HI = DATA_W - 2;
    localparam int EXP_LO = DATA_W - 1 - EXP_W;

    logic exp_is_zero;

    // Integer view: plain two's complement test.
    always_comb begin
        int_zero_o = (value_i == '0);
        int_neg_o  = value_i[SIGN_B];
    end

    // Float view: a zero exponent field forces positive zero.
    always_comb begin
        exp_is_zero = (value_i[EXP_HI:EXP_LO] == '0);
        fp_zero_o   = exp_is_zero;
        fp_neg_o    = value_i[SIGN_B] & ~exp_is_zero;
    end

endmodule

// File: rtl/fpflag_decode.sv
// Module: fpflag_decode
// Maps an operation code to the flag groups it refreshes.
// Assumes at most one operation per cycle; unknown or idle codes refresh nothing.
module fpflag_decode
    import fpflag_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output upd_t            upd_o
);
    // Decode one operation class into update enables.
    always_comb begin
        upd_o = '0;
        case (op_e'(op_i))
            OP_MOVA, OP_MOVB, OP_MOVC: begin
                upd_o.upd_int = 1'b1;
                upd_o.upd_fp  = 1'b1;
            end
            OP_ABS, OP_NEG, OP_CMP, OP_MAX, OP_MIN:
                upd_o.upd_fp = 1'b1;
            OP_MUL, OP_ADD, OP_SUB, OP_MAC, OP_RCP, OP_RSQ:
                upd_o.arith = 1'b1;
            OP_TEST:
                upd_o.upd_test = 1'b1;
            default: upd_o = '0;
        endcase
    end

endmodule

// File: rtl/fpflag_reg.sv
// Module: fpflag_reg
// Flag register with a per-bit merge. Precedence per bit, highest first:
// direct write, operation update, clear request, hold.
// Assumes synchronous active-low reset.
module fpflag_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_mask_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] upd_en_i,
    input  logic [W-1:0] upd_val_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] nxt;

    // Per-bit next-value selection by precedence.
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            if (wr_en_i && wr_mask_i[b])
                nxt[b] = wr_data_i[b];
            else if (upd_en_i[b])
                nxt[b] = upd_val_i[b];
            else if (clr_i[b])
                nxt[b] = 1'b0;
            else
                nxt[b] = q_o[b];
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else
            q_o <= nxt;
    end

endmodule

// File: rtl/fpflag_unit.sv
// Module: fpflag_unit (top)
// Floating-point status flag unit: refreshes seven flags from per-cycle
// operation results, keeps sticky under/overflow, accepts a masked direct
// write and a copy-out that exports the old flags and clears the sticky pair.
// Assumes one operation code per cycle and a single-precision value layout.
module fpflag_unit
    import fpflag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic              uf_i,
    input  logic              of_i,
    input  logic              cond_i,
    input  logic              wr_en_i,
    input  logic [FLAG_W-1:0] wr_mask_i,
    input  logic [FLAG_W-1:0] wr_data_i,
    input  logic              copy_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] copy_o
);
    upd_t              upd;
    logic              iz, ineg, fz, fneg;
    logic [FLAG_W-1:0] upd_en, upd_val, clr;

    fpflag_decode u_dec (
        .op_i  (op_i),
        .upd_o (upd)
    );

    fpflag_classify #(
        .DATA_W (DATA_W),
        .EXP_W  (EXP_W)
    ) u_cls (
        .value_i    (value_i),
        .int_zero_o (iz),
        .int_neg_o  (ineg),
        .fp_zero_o  (fz),
        .fp_neg_o   (fneg)
    );

    // Gather per-flag update enables and values from the decoded class.
    always_comb begin
        upd_en  = '0;
        upd_val = '0;
        upd_en[B_TEST]  = upd.upd_test;
        upd_val[B_TEST] = cond_i;
        upd_en[B_IZ]    = upd.upd_int;
        upd_val[B_IZ]   = iz;
        upd_en[B_IN]    = upd.upd_int;
        upd_val[B_IN]   = ineg;
        upd_en[B_FZ]    = upd.upd_fp;
        upd_val[B_FZ]   = fz;
        upd_en[B_FN]    = upd.upd_fp;
        upd_val[B_FN]   = fneg;
        upd_en[B_UF]    = upd.arith & uf_i;
        upd_val[B_UF]   = 1'b1;
        upd_en[B_OF]    = upd.arith & of_i;
        upd_val[B_OF]   = 1'b1;
    end

    // Copy-out clears only the sticky pair.
    always_comb begin
        clr       = '0;
        clr[B_UF] = copy_i;
        clr[B_OF] = copy_i;
    end

    fpflag_reg #(
        .W (FLAG_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_mask_i (wr_mask_i),
        .wr_data_i (wr_data_i),
        .upd_en_i  (upd_en),
        .upd_val_i (upd_val),
        .clr_i     (clr),
        .q_o       (flags_o)
    );

    // Export the pre-edge flags while a copy is strobed.
    always_comb copy_o = copy_i ? flags_o : '0;

endmodule

// File: rtl/fpflag_unit_chk.sv
// Module: fpflag_unit_chk
// Property checker for fpflag_unit, attached by bind. Observes ports only.
module fpflag_unit_chk
    import fpflag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_i,
    input logic              uf_i,
    input logic              of_i,
    input logic              wr_en_i,
    input logic [FLAG_W-1:0] wr_mask_i,
    input logic [FLAG_W-1:0] wr_data_i,
    input logic              copy_i,
    input logic [FLAG_W-1:0] flags_o,
    input logic [FLAG_W-1:0] copy_o
);
    logic is_arith;
    // Arithmetic class seen from the port side.
    always_comb is_arith = (op_i >= 4'd9) && (op_i <= 4'd14);

    // R1: reset clears every flag.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> flags_o == '0);

    // R5: sticky underflow holds without a copy or a masked write.
    a_r5_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[B_UF] && !copy_i && !(wr_en_i && wr_mask_i[B_UF]))
        |=> flags_o[B_UF]);

    // R6: overflow cannot rise without an arithmetic class or a write.
    a_r6_of_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_o[B_OF] && !is_arith && !(wr_en_i && wr_mask_i[B_OF]))
        |=> !flags_o[B_OF]);

    // R7: test flag moves only on the test code or a masked write.
    a_r7_test_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 4'd15 && !(wr_en_i && wr_mask_i[B_TEST]))
        |=> $stable(flags_o[B_TEST]));

    // R8: masked bits take the written data.
    a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((flags_o & $past(wr_mask_i)) == ($past(wr_data_i) & $past(wr_mask_i))));

    // R9: copy clears the sticky pair absent an event or a write.
    a_r9_copy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_i && !(is_arith && (uf_i || of_i)) && !wr_en_i)
        |=> flags_o[B_UF:B_OF] == 2'b00);

    // R9: copy output is zero outside a strobe.
    a_r9_copy_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_i |-> copy_o == '0);

    // R10: an overflow event survives a same-cycle copy.
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_i && is_arith && of_i && !(wr_en_i && wr_mask_i[B_OF]))
        |=> flags_o[B_OF]);

endmodule

bind fpflag_unit fpflag_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .uf_i      (uf_i),
    .of_i      (of_i),
    .wr_en_i   (wr_en_i),
    .wr_mask_i (wr_mask_i),
    .wr_data_i (wr_data_i),
    .copy_i    (copy_i),
    .flags_o   (flags_o),
    .copy_o    (copy_o)
);

// File: tb/fpflag_unit_tb_top.sv
module fpflag_unit_tb_top;
    localparam int CLK_HALF = 10; // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op_i;
    logic [31:0] value_i;
    logic        uf_i, of_i, cond_i, wr_en_i, copy_i;
    logic [6:0]  wr_mask_i, wr_data_i;
    logic [6:0]  flags_o, copy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #CLK_HALF clk = ~clk;

    fpflag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .value_i(value_i),
        .uf_i(uf_i), .of_i(of_i), .cond_i(cond_i), .wr_en_i(wr_en_i),
        .wr_mask_i(wr_mask_i), .wr_data_i(wr_data_i), .copy_i(copy_i),
        .flags_o(flags_o), .copy_o(copy_o)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] val;
        logic        uf;
        logic        of;
        logic        cond;
        logic        wr;
        logic [6:0]  mask;
        logic [6:0]  data;
        logic        cp;
        logic [6:0]  exp_flags;
        logic [6:0]  exp_copy;
    } vec_t;

    localparam int NV = 23;
    // Flags: [6] test [5] int zero [4] int neg [3] fp zero [2] fp neg [1] uf [0] of
    localparam vec_t VEC [NV] = '{
        '{4'd1,  32'h0000_0000, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0101000, 7'h00}, // R2 R3 zero
        '{4'd2,  32'hC000_0000, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0010100, 7'h00}, // R2 R3 -2.0
        '{4'd3,  32'h8000_0000, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0011000, 7'h00}, // R3 negative zero
        '{4'd5,  32'hBF80_0000, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0010100, 7'h00}, // R3 R4 negate
        '{4'd4,  32'h8000_0001, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0011000, 7'h00}, // R3 R4 neg denormal
        '{4'd6,  32'h3F80_0000, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0010000, 7'h00}, // R3 compare
        '{4'd7,  32'h007F_FFFF, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0011000, 7'h00}, // R3 pos denormal
        '{4'd8,  32'hFF80_0000, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0010100, 7'h00}, // R3 -inf
        '{4'd9,  32'h1234_5678, 1'b1,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0010110, 7'h00}, // R5 underflow
        '{4'd10, 32'h0000_0000, 1'b0,1'b1,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0010111, 7'h00}, // R5 overflow
        '{4'd0,  32'hFFFF_FFFF, 1'b0,1'b0,1'b1, 1'b0,7'h00,7'h00, 1'b0, 7'b0010111, 7'h00}, // R11 idle
        '{4'd15, 32'h0000_0000, 1'b0,1'b0,1'b1, 1'b0,7'h00,7'h00, 1'b0, 7'b1010111, 7'h00}, // R7 test true
        '{4'd0,  32'h0000_0000, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b1, 7'b1010100, 7'b1010111}, // R9 copy
        '{4'd1,  32'h0000_0001, 1'b1,1'b1,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b1001000, 7'h00}, // R6 ignored on move
        '{4'd15, 32'h0000_0000, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b0001000, 7'h00}, // R7 test false
        '{4'd11, 32'h0000_0000, 1'b0,1'b1,1'b0, 1'b0,7'h00,7'h00, 1'b1, 7'b0001001, 7'b0001000}, // R10 event vs copy
        '{4'd13, 32'h0000_0000, 1'b1,1'b1,1'b0, 1'b1,7'b0000011,7'h00, 1'b0, 7'b0001000, 7'h00}, // R8 write beats event
        '{4'd0,  32'h0000_0000, 1'b0,1'b0,1'b0, 1'b1,7'b1111111,7'b1010101, 1'b0, 7'b1010101, 7'h00}, // R8 full write
        '{4'd1,  32'h0000_0000, 1'b0,1'b0,1'b0, 1'b1,7'b0100000,7'h00, 1'b0, 7'b1001001, 7'h00}, // R8 write beats move
        '{4'd14, 32'h0000_0000, 1'b1,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b1001011, 7'h00}, // R5 rsqrt uf
        '{4'd12, 32'h0000_0000, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b0, 7'b1001011, 7'h00}, // R5 sticky hold
        '{4'd0,  32'h0000_0000, 1'b0,1'b0,1'b0, 1'b0,7'h00,7'h00, 1'b1, 7'b1001000, 7'b1001011}, // R9 copy
        '{4'd0,  32'h8000_0000, 1'b1,1'b1,1'b1, 1'b0,7'h00,7'h00, 1'b0, 7'b1001000, 7'h00}  // R11 R6 idle
    };

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        op_i = 4'd0; value_i = '0; uf_i = 0; of_i = 0; cond_i = 0;
        wr_en_i = 0; wr_mask_i = '0; wr_data_i = '0; copy_i = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive_idle();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", flags_o, 7'b0);
        check("R9 copy idle", copy_o, 7'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            op_i = VEC[i].op; value_i = VEC[i].val; uf_i = VEC[i].uf;
            of_i = VEC[i].of; cond_i = VEC[i].cond; wr_en_i = VEC[i].wr;
            wr_mask_i = VEC[i].mask; wr_data_i = VEC[i].data; copy_i = VEC[i].cp;
            #1;
            check($sformatf("R9 copy out vec %0d", i), copy_o, VEC[i].exp_copy);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R2-table vec %0d", i), flags_o, VEC[i].exp_flags);
        end

        // R1: reset in mid-run clears a populated register.
        drive_idle();
        wr_en_i = 1; wr_mask_i = 7'h7F; wr_data_i = 7'h7F;
        @(posedge clk); @(negedge clk);
        check("R8 all ones", flags_o, 7'h7F);
        drive_idle();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 mid-run reset", flags_o, 7'b0);
        rst_n = 1'b1;

        // R6: under/overflow on compare is ignored.
        op_i = 4'd6; value_i = 32'h3F80_0000; uf_i = 1; of_i = 1;
        @(posedge clk); @(negedge clk);
        check("R6 ignored on compare", flags_o, 7'b0);

        // R10: both events during copy, both survive.
        op_i = 4'd9; uf_i = 1; of_i = 1; copy_i = 1;
        #1;
        check("R9 copy before edge", copy_o, 7'b0);
        @(posedge clk); @(negedge clk);
        check("R10 both events survive copy", flags_o, 7'b0000011);
        drive_idle();
        finish_run();
    end
endmodule